// File: doc/BRIEF.md
# Command-Word Addressed Byte Memory

This block is a single-port byte store that is never handed an address on a bus. Every access arrives as a command word with a strobe. The two upper bits of the word name the operation and the lower eight bits carry its operand. Two address registers live inside the block: one for writes and one for reads. Earlier command words load these registers, and later data commands use them. A serial front end can therefore run the memory with nothing more than a stream of fixed-width words.

A read command places the addressed byte on the data output one clock later and raises a read-valid flag. The flag stays high until the next accepted command. The array depth and the address width are parameters. Addresses taken from the operand keep only their low bits. A depth below the address range leaves some addresses unbacked: writes to them are dropped and reads from them return zero.

Top module: `cmd_ram`

## Requirements
- R1: Asserting `rst_n` low clears `rd_valid`, `rd_data` and both address registers at once, without waiting for a clock edge. The array contents are left as they were.
- R2: An accepted word with operation bits `cmd_word[9:8]` = 00 loads the write-address register from the low `ADDR_W` bits of the operand `cmd_word[7:0]`. Operand bits above those are ignored.
- R3: An accepted word with operation 01 stores the operand byte at the held write address. The write address is kept, so repeated 01 words overwrite the same location.
- R4: An accepted word with operation 10 loads the read-address register from the low `ADDR_W` operand bits.
- R5: An accepted word with operation 11 drives the byte at the held read address on `rd_data` and raises `rd_valid`, both on the clock edge that accepts the word.
- R6: An accepted word with operation 00, 01 or 10 clears `rd_valid` on its accepting edge. Otherwise `rd_valid` stays high after a read until the next accepted word.
- R7: A word presented while `cmd_valid` is low has no effect on the array, on either address register or on the outputs.
- R8: An operation 01 that arrives after reset, before any operation 00, writes to address 0.
- R9: A write to an address at or above `DEPTH` is discarded. A read from such an address returns zero.
- R10: The read and write address registers are independent. Loading one never moves the other.
- R11: `rd_data` changes only on an accepted read or on reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Strobe qualifying `cmd_word` in this cycle |
| cmd_word | input | DATA_W+2 | Operation in the top two bits, operand below them |
| rd_data | output | DATA_W | Byte returned by the last read |
| rd_valid | output | 1 | High from an accepted read until the next accepted word |

## Verification
The bench builds the block with `ADDR_W` = 4 and `DEPTH` = 12. The small array lets every location be filled and read back, and it places addresses 12 to 15 in the unbacked range, where the discard-and-zero rule of R9 applies. The 4-bit address also means each random operand carries upper bits that must be dropped, which exercises the truncation of R2 and R4. A fixed-seed random command mix then runs against a model of the array and both address registers. Directed sequences cover a write before any address load, a reset while `rd_valid` is high, and independence of the two addresses.

// File: rtl/cmd_ram.sv
module cmd_ram #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [DATA_W+1:0] cmd_word,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  typedef enum logic [1:0] {
    OP_SET_WA = 2'b00,
    OP_WRITE  = 2'b01,
    OP_SET_RA = 2'b10,
    OP_READ   = 2'b11
  } op_t;

  localparam logic [ADDR_W:0] DEPTH_L = DEPTH[ADDR_W:0];

  op_t               op;
  logic [DATA_W-1:0] operand;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              wr_in_range, rd_in_range;
  logic [DATA_W-1:0] mem [DEPTH];

  assign op          = op_t'(cmd_word[DATA_W+1:DATA_W]);
  assign operand     = cmd_word[DATA_W-1:0];
  assign wr_in_range = {1'b0, wr_addr} < DEPTH_L;
  assign rd_in_range = {1'b0, rd_addr} < DEPTH_L;

  always_ff @(posedge clk)
    if (cmd_valid && op == OP_WRITE && wr_in_range)
      mem[wr_addr] <= operand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr  <= '0;
      rd_addr  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else if (cmd_valid) begin
      rd_valid <= (op == OP_READ);
      unique case (op)
        OP_SET_WA: wr_addr <= operand[ADDR_W-1:0];
        OP_SET_RA: rd_addr <= operand[ADDR_W-1:0];
        OP_READ:   rd_data <= rd_in_range ? mem[rd_addr] : '0;
        default: ;
      endcase
    end
  end

  initial assert (ADDR_W <= DATA_W && DEPTH <= (1 << ADDR_W) && DEPTH > 0)
    else $error("cmd_ram: parameter set out of range");

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(rd_valid) && $stable(rd_data) && $stable(wr_addr) && $stable(rd_addr));

  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op != OP_READ |=> !rd_valid);

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == OP_READ |=> rd_valid);

  p_data_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op != OP_READ |=> $stable(rd_data));

  p_oob_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == OP_READ && !rd_in_range |=> rd_data == '0);

  p_addr_indep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == OP_SET_WA |=> $stable(rd_addr));

endmodule

// File: tb/cmd_ram_tb.sv
`timescale 1ns/1ps
module cmd_ram_tb;
  localparam int AW = 4;
  localparam int DP = 12;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [DW+1:0] cmd_word = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int checks = 0;
  int failures = 0;
  int m_mem [1 << AW];
  int m_wa = 0, m_ra = 0, m_dout = 0;
  bit m_v = 1'b0;

  cmd_ram #(.ADDR_W(AW), .DEPTH(DP), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .rd_data(rd_data), .rd_valid(rd_valid));

  always #2.5 clk = ~clk;

  function automatic int ref_read(int a);
    return (a < DP) ? m_mem[a] : 0;
  endfunction

  function automatic int trunc(int pl);
    return pl % (1 << AW);
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_wa = 0; m_ra = 0; m_dout = 0; m_v = 1'b0;
  endtask

  task automatic step(bit v, bit [1:0] op, bit [7:0] pl, string tag);
    cmd_valid = v;
    cmd_word  = {op, pl};
    @(posedge clk);
    if (v) begin
      m_v = (op == 2'b11);
      case (op)
        2'b00: m_wa = trunc(pl);
        2'b01: if (m_wa < DP) m_mem[m_wa] = pl;
        2'b10: m_ra = trunc(pl);
        default: m_dout = ref_read(m_ra);
      endcase
    end
    @(negedge clk);
    check({tag, " valid"}, int'(rd_valid), int'(m_v));
    check({tag, " data"}, int'(rd_data), m_dout);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < (1 << AW); i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(rd_valid), 0);
    check("R1 reset data", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: write before any address load lands at 0
    step(1, 2'b01, 8'hA5, "R8 write");
    step(1, 2'b10, 8'h00, "R4 load ra");
    step(1, 2'b11, 8'h00, "R8 read");

    // R2/R3 fill every address, including unbacked ones (R9)
    for (int a = 0; a < (1 << AW); a++) begin
      step(1, 2'b00, 8'(a | 8'h30), "R2 load wa");
      step(1, 2'b01, 8'(8'h11 * a + 3), a >= DP ? "R9 oob write" : "R3 write");
    end
    for (int a = 0; a < (1 << AW); a++) begin
      step(1, 2'b10, 8'(a | 8'hC0), "R4 load ra");
      step(1, 2'b11, 8'($urandom), a >= DP ? "R9 oob read" : "R5 read");
    end

    // R3 repeated writes overwrite one location
    step(1, 2'b00, 8'h05, "R2 load wa");
    step(1, 2'b01, 8'h11, "R3 write");
    step(1, 2'b01, 8'h22, "R3 rewrite");
    step(1, 2'b10, 8'h05, "R4 load ra");
    step(1, 2'b11, 8'h00, "R3 readback");

    // R10 independent addresses
    step(1, 2'b10, 8'h07, "R10 load ra");
    step(1, 2'b00, 8'h03, "R10 load wa");
    step(1, 2'b01, 8'h99, "R10 write");
    step(1, 2'b11, 8'h00, "R10 read other");

    // R6/R7/R11 flag and data hold
    step(0, 2'b00, 8'h01, "R7 idle hold");
    step(0, 2'b01, 8'h77, "R7 ignored write");
    step(0, 2'b10, 8'h03, "R7 ignored ra");
    step(1, 2'b11, 8'h00, "R7 read unchanged");
    step(1, 2'b00, 8'h09, "R6 clear on wa");
    step(1, 2'b11, 8'h00, "R5 read again");
    step(1, 2'b01, 8'h44, "R6 clear on write");
    step(1, 2'b10, 8'h03, "R11 hold on ra");
    step(1, 2'b11, 8'h00, "R5 read wa target");

    // R1 asynchronous reset while rd_valid high
    #1 rst_n = 1'b0;
    #1;
    check("R1 async valid", int'(rd_valid), 0);
    check("R1 async data", int'(rd_data), 0);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 2'b01, 8'h5C, "R8 write after reset");
    step(1, 2'b11, 8'h00, "R1 ra cleared");

    // random mix
    for (int i = 0; i < 800; i++)
      step(($urandom % 5) != 0, 2'($urandom), 8'($urandom), "R5 random");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule